// File: doc/BRIEF.md
# Per-Class Function Count Coverage Checker

This block keeps two histograms over lookup-table function classes. A function class is an index for a non-constant lookup-table function that stays the same when its inputs are permuted. One histogram counts how many times each class occurs in a reference core. The other counts how many times it occurs in a design read back from a finished product. Class indices arrive one per cycle on a load port, which carries a flag that picks the histogram. An upstream canonicalization stage has already turned each lookup-table value into its class index.

When both histograms are loaded, a scan command walks every class in turn. For each class the scan reports whether that class's lookup tables can only belong to the core (the design count equals the core count) or are shared with other logic (the design count is larger). At the end the block gives a verdict. The core may be present only if no class has a design count below its core count. The block also reports how many of the core's lookup tables were found, the core total and the design total.

Reset starts a full clear of both histograms, and a clear command repeats it later, one class per cycle.

Top module: `cov_count_checker`

## Requirements
- R1: After reset is released, and after a clear command accepted while idle, `busy` stays high for exactly NUM_CLASSES cycles while both histograms are zeroed, one class per cycle. A scan after a clear reports all totals as zero and `contained` as 1.
- R2: A load accepted while idle increments one count by one: the core count when `ld_hist` is 0, the design count when `ld_hist` is 1, for the class given on `ld_class`.
- R3: A load is ignored when `ld_const` is 1 (constant function), when `ld_class` is NUM_CLASSES or above, or when `busy` is high.
- R4: Each count saturates at 2^CNT_W-1. Further loads to that class leave it unchanged.
- R5: A scan accepted while idle visits classes 0 to NUM_CLASSES-1 in ascending order, one per cycle. `mark_valid` is high with `mark_class` giving the class. The first mark appears one cycle after the start edge, and the last mark appears NUM_CLASSES cycles after that edge.
- R6: During a mark, `mark_excl` is 1 exactly when the core count is non-zero and the design count equals it. `mark_shared` is 1 exactly when the core count is non-zero and the design count exceeds it.
- R7: `contained` is 1 exactly when the design count is at least the core count for every class.
- R8: `found_cnt` is the sum over classes of min(core, design). `core_total` and `design_total` are the sums of the core and design counts.
- R9: `done` pulses for one cycle, together with the mark of the last class. The results then hold until the next scan ends, unchanged by loads. A scan or clear command given while `busy` is high is ignored. If clear and scan are requested in the same idle cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clear |
| clr_req | input | 1 | Request a clear of both histograms |
| ld_valid | input | 1 | Load strobe |
| ld_hist | input | 1 | 0 = core histogram, 1 = design histogram |
| ld_class | input | IDX_W | Class index to count |
| ld_const | input | 1 | The loaded function is constant; load ignored |
| scan_start | input | 1 | Start a scan over all classes |
| busy | output | 1 | Clear or scan in progress |
| mark_valid | output | 1 | Per-class mark valid |
| mark_class | output | IDX_W | Class of the current mark |
| mark_excl | output | 1 | Class lookup tables belong only to the core |
| mark_shared | output | 1 | Class also occurs outside the core |
| done | output | 1 | One-cycle end-of-scan pulse |
| contained | output | 1 | Core may be present |
| found_cnt | output | TOT_W | Core lookup tables found in the design |
| core_total | output | TOT_W | Sum of core counts |
| design_total | output | TOT_W | Sum of design counts |

## Verification
A count corrupted by a missed increment, a lost saturation or a stray clear stays invisible until the next scan. It then shows at the ports in the cycle that class is marked, as a wrong exclusive or shared flag. The same scan's `done` cycle shows it again, in `found_cnt`, the totals and the verdict. A slip in the scan pointer shows as soon as it happens, because each mark must name the class after the previous one and `done` must come exactly NUM_CLASSES cycles after the start edge. The bench therefore rescans after every load pattern. It compares each mark in turn against counts kept from the requirements.

// File: rtl/cov_pkg.sv
package cov_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_SCAN  = 2'd2
    } cov_state_e;

    localparam logic SEL_CORE   = 1'b0;
    localparam logic SEL_DESIGN = 1'b1;

    typedef struct packed {
        logic ok;      // design count covers core count
        logic excl;    // class owned by the core only
        logic shared;  // class also used outside the core
    } class_verdict_t;

    function automatic class_verdict_t judge(input logic [31:0] core_c,
                                             input logic [31:0] des_c);
        class_verdict_t v;
        v.ok     = (des_c >= core_c);
        v.excl   = (core_c != 32'd0) && (des_c == core_c);
        v.shared = (core_c != 32'd0) && (des_c > core_c);
        return v;
    endfunction

    function automatic logic [31:0] smaller(input logic [31:0] a,
                                            input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cov_hist_store.sv
module cov_hist_store #(
    parameter int NUM_CLASSES = 3982,
    parameter int CNT_W       = 16,
    parameter int IDX_W       = 12
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_addr,
    input  logic             inc_en,
    input  logic             inc_sel,
    input  logic [IDX_W-1:0] inc_addr,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_core,
    output logic [CNT_W-1:0] rd_design
);
    localparam int WORD_W = 2 * CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // one word per class: low half core count, high half design count
    logic [WORD_W-1:0] bank [NUM_CLASSES];
    logic [WORD_W-1:0] inc_word;
    logic [WORD_W-1:0] inc_next;

    assign inc_word = bank[inc_addr];

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic [CNT_W-1:0] old_v;
            logic [CNT_W-1:0] bumped;
            logic             hit;
            assign old_v  = inc_word[h*CNT_W +: CNT_W];
            assign bumped = (old_v == CNT_MAX) ? old_v : old_v + CNT_W'(1);
            assign hit    = (int'(inc_sel) == h);
            assign inc_next[h*CNT_W +: CNT_W] = hit ? bumped : old_v;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr_en) begin
            bank[clr_addr] <= '0;
        end else if (inc_en) begin
            bank[inc_addr] <= inc_next;
        end
    end

    assign {rd_design, rd_core} = bank[rd_addr];

endmodule

// File: rtl/cov_seq_ctl.sv
module cov_seq_ctl
    import cov_pkg::*;
#(
    parameter int NUM_CLASSES = 3982,
    parameter int IDX_W       = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic             scan_req,
    output cov_state_e       state,
    output logic [IDX_W-1:0] ptr,
    output logic             last,
    output logic             busy,
    output logic             scan_go
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CLASSES - 1);

    assign last    = (ptr == LAST_IDX);
    assign busy    = (state != ST_IDLE);
    assign scan_go = (state == ST_IDLE) && !clr_req && scan_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
            ptr   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    ptr <= '0;
                    if (clr_req) begin
                        state <= ST_CLEAR;
                    end else if (scan_req) begin
                        state <= ST_SCAN;
                    end
                end
                ST_CLEAR, ST_SCAN: begin
                    if (last) begin
                        state <= ST_IDLE;
                        ptr   <= '0;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    ptr   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cov_scan_accum.sv
module cov_scan_accum
    import cov_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = 12,
    parameter int TOT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_go,
    input  logic             step,
    input  logic             last,
    input  logic [IDX_W-1:0] ptr,
    input  logic [CNT_W-1:0] core_cnt,
    input  logic [CNT_W-1:0] des_cnt,
    output logic             mark_valid,
    output logic [IDX_W-1:0] mark_class,
    output logic             mark_excl,
    output logic             mark_shared,
    output logic             done,
    output logic             contained,
    output logic [TOT_W-1:0] found_cnt,
    output logic [TOT_W-1:0] core_total,
    output logic [TOT_W-1:0] design_total
);
    class_verdict_t   verdict;
    logic [CNT_W-1:0] overlap;
    logic             ok_run,    ok_nxt;
    logic [TOT_W-1:0] found_run, found_nxt;
    logic [TOT_W-1:0] n_run,     n_nxt;
    logic [TOT_W-1:0] m_run,     m_nxt;

    always_comb begin
        verdict   = judge(32'(core_cnt), 32'(des_cnt));
        overlap   = CNT_W'(smaller(32'(core_cnt), 32'(des_cnt)));
        ok_nxt    = ok_run && verdict.ok;
        found_nxt = found_run + TOT_W'(overlap);
        n_nxt     = n_run + TOT_W'(core_cnt);
        m_nxt     = m_run + TOT_W'(des_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_run       <= 1'b1;
            found_run    <= '0;
            n_run        <= '0;
            m_run        <= '0;
            mark_valid   <= 1'b0;
            mark_class   <= '0;
            mark_excl    <= 1'b0;
            mark_shared  <= 1'b0;
            done         <= 1'b0;
            contained    <= 1'b0;
            found_cnt    <= '0;
            core_total   <= '0;
            design_total <= '0;
        end else begin
            mark_valid  <= step;
            mark_excl   <= step && verdict.excl;
            mark_shared <= step && verdict.shared;
            done        <= step && last;
            if (scan_go) begin
                ok_run    <= 1'b1;
                found_run <= '0;
                n_run     <= '0;
                m_run     <= '0;
            end else if (step) begin
                mark_class <= ptr;
                ok_run     <= ok_nxt;
                found_run  <= found_nxt;
                n_run      <= n_nxt;
                m_run      <= m_nxt;
                if (last) begin
                    contained    <= ok_nxt;
                    found_cnt    <= found_nxt;
                    core_total   <= n_nxt;
                    design_total <= m_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/cov_count_checker.sv
module cov_count_checker
    import cov_pkg::*;
#(
    parameter int NUM_CLASSES = 3982,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    localparam int TOT_W      = CNT_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic             ld_valid,
    input  logic             ld_hist,
    input  logic [IDX_W-1:0] ld_class,
    input  logic             ld_const,
    input  logic             scan_start,
    output logic             busy,
    output logic             mark_valid,
    output logic [IDX_W-1:0] mark_class,
    output logic             mark_excl,
    output logic             mark_shared,
    output logic             done,
    output logic             contained,
    output logic [TOT_W-1:0] found_cnt,
    output logic [TOT_W-1:0] core_total,
    output logic [TOT_W-1:0] design_total
);
    localparam logic [IDX_W:0] CLASS_LIMIT = (IDX_W+1)'(NUM_CLASSES);

    cov_state_e       state;
    logic [IDX_W-1:0] ptr;
    logic             last;
    logic             scan_go;
    logic             ld_ok;
    logic [CNT_W-1:0] rd_core;
    logic [CNT_W-1:0] rd_design;

    assign ld_ok = ld_valid && !ld_const && !busy
                && ({1'b0, ld_class} < CLASS_LIMIT);

    cov_seq_ctl #(
        .NUM_CLASSES(NUM_CLASSES),
        .IDX_W      (IDX_W)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .clr_req (clr_req),
        .scan_req(scan_start),
        .state   (state),
        .ptr     (ptr),
        .last    (last),
        .busy    (busy),
        .scan_go (scan_go)
    );

    cov_hist_store #(
        .NUM_CLASSES(NUM_CLASSES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk      (clk),
        .clr_en   (state == ST_CLEAR),
        .clr_addr (ptr),
        .inc_en   (ld_ok),
        .inc_sel  (ld_hist),
        .inc_addr (ld_class),
        .rd_addr  (ptr),
        .rd_core  (rd_core),
        .rd_design(rd_design)
    );

    cov_scan_accum #(
        .CNT_W(CNT_W),
        .IDX_W(IDX_W),
        .TOT_W(TOT_W)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .scan_go     (scan_go),
        .step        (state == ST_SCAN),
        .last        (last),
        .ptr         (ptr),
        .core_cnt    (rd_core),
        .des_cnt     (rd_design),
        .mark_valid  (mark_valid),
        .mark_class  (mark_class),
        .mark_excl   (mark_excl),
        .mark_shared (mark_shared),
        .done        (done),
        .contained   (contained),
        .found_cnt   (found_cnt),
        .core_total  (core_total),
        .design_total(design_total)
    );

endmodule

// File: rtl/cov_count_checker_chk.sv
module cov_count_checker_chk #(
    parameter int NUM_CLASSES = 3982,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    localparam int TOT_W      = CNT_W + IDX_W
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             mark_valid,
    input logic [IDX_W-1:0] mark_class,
    input logic             mark_excl,
    input logic             mark_shared,
    input logic             done,
    input logic             contained,
    input logic [TOT_W-1:0] found_cnt,
    input logic [TOT_W-1:0] core_total,
    input logic [TOT_W-1:0] design_total
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CLASSES - 1);

    // R5
    ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mark_valid && $past(mark_valid)) |-> (mark_class == $past(mark_class) + IDX_W'(1)));

    // R5
    mark_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
        mark_valid |-> $past(busy));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (mark_excl || mark_shared) |-> (mark_valid && !(mark_excl && mark_shared)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (mark_valid && mark_class == LAST_IDX && !busy));

    // R8
    found_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (found_cnt <= core_total && found_cnt <= design_total));

    // R7
    full_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (done && contained) |-> (found_cnt == core_total));

endmodule

bind cov_count_checker cov_count_checker_chk #(
    .NUM_CLASSES(NUM_CLASSES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .mark_valid  (mark_valid),
    .mark_class  (mark_class),
    .mark_excl   (mark_excl),
    .mark_shared (mark_shared),
    .done        (done),
    .contained   (contained),
    .found_cnt   (found_cnt),
    .core_total  (core_total),
    .design_total(design_total)
);

// File: tb/sim_cov_count_checker.sv
module sim_cov_count_checker;
    localparam int N   = 13;
    localparam int CW  = 4;
    localparam int IW  = $clog2(N);
    localparam int TW  = CW + IW;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_req = 1'b0;
    logic          ld_valid = 1'b0;
    logic          ld_hist = 1'b0;
    logic [IW-1:0] ld_class = '0;
    logic          ld_const = 1'b0;
    logic          scan_start = 1'b0;
    logic          busy, mark_valid, mark_excl, mark_shared, done, contained;
    logic [IW-1:0] mark_class;
    logic [TW-1:0] found_cnt, core_total, design_total;

    always #4 clk = ~clk;

    cov_count_checker #(.NUM_CLASSES(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .clr_req(clr_req), .ld_valid(ld_valid),
        .ld_hist(ld_hist), .ld_class(ld_class), .ld_const(ld_const),
        .scan_start(scan_start), .busy(busy), .mark_valid(mark_valid),
        .mark_class(mark_class), .mark_excl(mark_excl), .mark_shared(mark_shared),
        .done(done), .contained(contained), .found_cnt(found_cnt),
        .core_total(core_total), .design_total(design_total)
    );

    typedef struct {
        int cls;
        bit excl;
        bit shr;
    } exp_mark_t;

    int        checks = 0;
    int        fails  = 0;
    int        cyc    = 0;
    int        core_m [N];
    int        des_m  [N];
    exp_mark_t q [$];
    bit        scan_pending = 0;
    bit        exp_cont;
    int        exp_found, exp_n, exp_m;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    // monitor: pops expected marks and final results
    always @(negedge clk) begin
        if (!rst) begin
            if (mark_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R5 unexpected mark", int'(mark_class), -1);
                end else begin
                    exp_mark_t e;
                    e = q.pop_front();
                    chk(int'(mark_class) == e.cls, "R5 mark class", int'(mark_class), e.cls);
                    chk(mark_excl == e.excl, "R6 exclusive flag", int'(mark_excl), int'(e.excl));
                    chk(mark_shared == e.shr, "R6 shared flag", int'(mark_shared), int'(e.shr));
                end
            end
            if (done) begin
                chk(scan_pending, "R9 done without scan", 1, int'(scan_pending));
                chk(contained == exp_cont, "R7 contained", int'(contained), int'(exp_cont));
                chk(int'(found_cnt) == exp_found, "R8 found count", int'(found_cnt), exp_found);
                chk(int'(core_total) == exp_n, "R8 core total", int'(core_total), exp_n);
                chk(int'(design_total) == exp_m, "R8 design total", int'(design_total), exp_m);
                chk(q.size() == 0, "R5 marks missing", q.size(), 0);
                scan_pending = 0;
            end
        end
    end

    task automatic load(input bit sel, input int cls, input bit cst);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_hist  = sel;
        ld_class = IW'(cls);
        ld_const = cst;
        // R2 counted, R3 ignored cases, R4 saturation
        if (!cst && cls < N && !busy) begin
            if (sel) des_m[cls]  = (des_m[cls]  < MAXC) ? des_m[cls] + 1  : MAXC;
            else     core_m[cls] = (core_m[cls] < MAXC) ? core_m[cls] + 1 : MAXC;
        end
        @(negedge clk);
        ld_valid = 1'b0;
        ld_const = 1'b0;
    endtask

    task automatic push_expected();
        exp_cont  = 1;
        exp_found = 0;
        exp_n     = 0;
        exp_m     = 0;
        for (int k = 0; k < N; k++) begin
            exp_mark_t e;
            e.cls  = k;
            e.excl = (core_m[k] != 0) && (des_m[k] == core_m[k]);
            e.shr  = (core_m[k] != 0) && (des_m[k] > core_m[k]);
            q.push_back(e);
            if (des_m[k] < core_m[k]) exp_cont = 0;
            exp_found += (des_m[k] < core_m[k]) ? des_m[k] : core_m[k];
            exp_n     += core_m[k];
            exp_m     += des_m[k];
        end
        scan_pending = 1;
    endtask

    // disturb = 1: re-issue scan, clear and a load while the scan runs (R9, R3)
    task automatic run_scan(input bit disturb);
        int cnt;
        push_expected();
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        cnt = 0;
        while (!done) begin
            @(negedge clk);
            cnt++;
            if (disturb && cnt == 3) begin
                scan_start = 1'b1;
                clr_req    = 1'b1;
                ld_valid   = 1'b1;
                ld_hist    = 1'b1;
                ld_class   = IW'(N - 1);
            end else begin
                scan_start = 1'b0;
                clr_req    = 1'b0;
                ld_valid   = 1'b0;
            end
        end
        chk(cnt == N, "R5 scan length", cnt, N);
        @(negedge clk);
        chk(!busy, "R9 idle after scan", int'(busy), 0);
        chk(!done, "R9 done single cycle", int'(done), 0);
    endtask

    initial begin
        int cnt;
        for (int k = 0; k < N; k++) begin
            core_m[k] = 0;
            des_m[k]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and clear length
        chk(busy, "R1 busy after reset", int'(busy), 1);
        chk(!done && !mark_valid, "R9 no done at reset", int'(done), 0);
        chk(found_cnt == '0, "R8 found at reset", int'(found_cnt), 0);
        cnt = 0;
        while (busy) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == N, "R1 reset clear length", cnt, N);

        // R1 empty histograms
        run_scan(0);

        // R2 R6 R7 pattern: excl, shared, short, design-only
        repeat (2) load(0, 1, 0);
        load(0, 3, 0);
        repeat (4) load(0, 5, 0);
        repeat (2) load(1, 1, 0);
        repeat (3) load(1, 3, 0);
        load(1, 5, 0);
        repeat (2) load(1, 7, 0);
        run_scan(0);

        // R9 results hold while loads happen
        begin
            logic [TW-1:0] f0;
            f0 = found_cnt;
            load(1, 5, 0);
            chk(found_cnt == f0, "R9 result hold", int'(found_cnt), int'(f0));
        end

        // R7 now covered everywhere
        repeat (2) load(1, 5, 0);
        run_scan(0);

        // R3 ignored loads: constant, out of range
        load(1, 4, 1);
        load(0, 6, 1);
        load(0, 14, 0);
        load(1, 15, 0);
        load(1, 0, 0);
        run_scan(0);

        // R4 saturation at 15
        repeat (20) load(0, 2, 0);
        repeat (17) load(1, 2, 0);
        repeat (18) load(0, 12, 0);
        run_scan(0);

        // R9 R3 commands and load during scan are ignored
        run_scan(1);
        run_scan(0);

        // R9 clear wins over scan in same cycle; R1 clear zeroes
        @(negedge clk);
        clr_req    = 1'b1;
        scan_start = 1'b1;
        @(negedge clk);
        clr_req    = 1'b0;
        scan_start = 1'b0;
        cnt = 0;
        while (busy) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == N, "R1 clear command length", cnt, N);
        chk(!scan_pending && q.size() == 0, "R9 scan not started", q.size(), 0);
        for (int k = 0; k < N; k++) begin
            core_m[k] = 0;
            des_m[k]  = 0;
        end
        run_scan(0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule